// File: doc/BRIEF.md
# Frame Trigger Handshake and Status Controller

This block owns the command register of a multichannel output stage that updates all channels together on a frame trigger. From the command word it picks the trigger source (a one-cycle pulse from an external-to-block timer, or an asynchronous external pin), gates the trigger with an enable bit, drives four digital outputs, and selects which of five interrupt request lines carries trigger interrupts. It assembles a 16-bit status word that the host polls.

The handshake is a small state machine with three named states. `HS_OFF` is the state while trigger updating is disabled. `HS_LOADING` means the host is filling the next frame and the ready flag is low. `HS_ARMED` means the host has written the update register and the ready flag is high. Its transitions are:
- *enable*: from `HS_OFF` to `HS_LOADING`, on a command write with the enable bit set.
- *arm*: from `HS_LOADING` to `HS_ARMED`, on an update-register write.
- *fire*: from `HS_ARMED` to `HS_LOADING`, on an accepted trigger.
- *disable*: from any state to `HS_OFF`, on a command write with the enable bit clear.

A trigger seen in `HS_LOADING` means a frame was lost, and it sets a sticky overrun flag. Every accepted trigger also leaves the block as a one-cycle simultaneous-update strobe for the channel register file.

Top module: `frame_trig_ctrl`

## Requirements
- R1: After reset the command register is zero. `dout`, `upd_strobe` and `irq_lines` are 0, and status bits 15, 14 and 7..4 are 0.
- R2: A command write loads the register in the next cycle. `dout` takes data bits 3..0, `auto_inc` takes bit 4 and `hold_mode` takes bit 7. Bit 5 selects the external trigger and bit 6 enables trigger updating.
- R3: The status word is: bit 15 ready, bit 14 overrun, bits 13..12 zero, bits 11..8 `cur_chan`, bits 7..4 the command bits 7..4, and bits 3..0 the live `din` value.
- R4: With trigger updating enabled, an update-register write sets ready (status bit 15) in the next cycle. The next accepted trigger clears it.
- R5: With trigger updating disabled, triggers have no effect: no strobe, no interrupt and no overrun. Ready stays 0 even after update-register writes.
- R6: With trigger updating enabled, a trigger that arrives while ready is 0 sets overrun (status bit 14). Overrun stays set until a command write, and any command write clears it.
- R7: With bit 5 = 0 only `int_trig` pulses count. With bit 5 = 1 only rising edges of `ext_trig` count, through a two-flop synchronizer and an edge detector, and they act on the third clock edge after the rise. A held-high `ext_trig` gives a single trigger.
- R8: Each accepted trigger produces a single-cycle `upd_strobe` in the cycle after the trigger.
- R9: With bit 6 = 0 and bit 7 = 1, an update-register write produces a single-cycle `upd_strobe` in the next cycle. With bit 7 = 0 it produces none.
- R10: The interrupt field, bits 10..8, maps codes 1..5 to `irq_lines` bits 0..4 (IRQ7, IRQ9, IRQ10, IRQ11, IRQ15). Codes 0, 6 and 7 drive no line.
- R11: An accepted trigger sets a sticky request, which appears on the selected line in the next cycle. A status read or a command write clears it. If a set and a clear come in the same cycle, the set wins.
- R12: At most one bit of `irq_lines` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 16 | Command write data |
| upd_wr | input | 1 | Update register write strobe (data ignored) |
| stat_rd | input | 1 | Status read strobe |
| cur_chan | input | 4 | Current channel address from the addressing logic |
| din | input | 4 | Digital inputs |
| int_trig | input | 1 | One-cycle internal timer trigger |
| ext_trig | input | 1 | Asynchronous external trigger |
| stat_word | output | 16 | Status word |
| dout | output | 4 | Digital outputs |
| auto_inc | output | 1 | Auto-increment mode bit |
| hold_mode | output | 1 | Hold/simultaneous mode bit |
| upd_strobe | output | 1 | Simultaneous update strobe |
| irq_lines | output | 5 | Interrupt request lines |

## Verification
Command fields, ready, overrun, the interrupt request and `upd_strobe` all come from one register stage. Each is therefore due one clock edge after the write, read or internal pulse that causes it. The external trigger passes three edges (two sync flops and the edge flop) before it acts. The bench checks ready both after two edges, when it must not yet have changed, and after three. Stimulus is applied at the falling edge and results are sampled at the next falling edge, so every check falls in the one cycle where the result is due. Strobe pulses are also checked low one cycle later.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

    localparam int CMD_BITS  = 11;
    localparam int IRQ_LINES = 5;
    localparam int LVL_BITS  = 3;
    localparam int DIO_BITS  = 4;

    typedef struct packed {
        logic [LVL_BITS-1:0] irq_lvl;
        logic                hold;
        logic                trig_en;
        logic                ext_sel;
        logic                auto_inc;
        logic [DIO_BITS-1:0] dout;
    } cmd_t;

    typedef enum logic [1:0] {
        HS_OFF     = 2'd0,
        HS_LOADING = 2'd1,
        HS_ARMED   = 2'd2
    } hs_state_t;

endpackage

// File: rtl/ftc_trig_sync.sv
module ftc_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_async,
    input  logic int_pulse,
    input  logic ext_sel,
    output logic trig_pulse
);

    logic [SYNC_STAGES:0] chain_q;
    logic                 ext_edge;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-1:0], ext_async};
        end
    end

    // rising edge of the synchronized level
    assign ext_edge   = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    assign trig_pulse = ext_sel ? ext_edge : int_pulse;

endmodule

// File: rtl/ftc_handshake.sv
module ftc_handshake
    import ftc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic cmd_en,
    input  logic upd_wr,
    input  logic trig,
    output logic ready,
    output logic overrun,
    output logic acc_trig
);

    hs_state_t state_q, state_d;
    logic      overrun_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_OFF:     if (cmd_wr && cmd_en) state_d = HS_LOADING;
            HS_LOADING: if (upd_wr)           state_d = HS_ARMED;
            HS_ARMED:   if (trig)             state_d = HS_LOADING;
            default:                          state_d = HS_OFF;
        endcase
        if (cmd_wr && !cmd_en) begin
            state_d = HS_OFF;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun_q <= 1'b0;
        end else if (cmd_wr) begin
            overrun_q <= 1'b0;
        end else if (trig && state_q == HS_LOADING) begin
            overrun_q <= 1'b1;
        end
    end

    always_comb begin
        acc_trig = trig && (state_q != HS_OFF);
        ready    = (state_q == HS_ARMED);
        overrun  = overrun_q;
    end

endmodule

// File: rtl/ftc_irq.sv
module ftc_irq
    import ftc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LVL_BITS-1:0]  lvl,
    input  logic                 set,
    input  logic                 clr,
    output logic [IRQ_LINES-1:0] lines
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (set) begin
            pend_q <= 1'b1;
        end else if (clr) begin
            pend_q <= 1'b0;
        end
    end

    for (genvar i = 0; i < IRQ_LINES; i++) begin : g_line
        assign lines[i] = pend_q && (lvl == LVL_BITS'(i + 1));
    end

endmodule

// File: rtl/frame_trig_ctrl.sv
module frame_trig_ctrl
    import ftc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr,
    input  logic [15:0]          cmd_wdata,
    input  logic                 upd_wr,
    input  logic                 stat_rd,
    input  logic [3:0]           cur_chan,
    input  logic [DIO_BITS-1:0]  din,
    input  logic                 int_trig,
    input  logic                 ext_trig,
    output logic [15:0]          stat_word,
    output logic [DIO_BITS-1:0]  dout,
    output logic                 auto_inc,
    output logic                 hold_mode,
    output logic                 upd_strobe,
    output logic [IRQ_LINES-1:0] irq_lines
);

    cmd_t cmd_q;
    logic trig_raw;
    logic acc_trig;
    logic ready;
    logic overrun;
    logic trig_en_q;
    logic strobe_q;
    logic unused_cmd_hi;

    assign unused_cmd_hi = ^cmd_wdata[15:CMD_BITS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (cmd_wr) begin
            cmd_q <= cmd_t'(cmd_wdata[CMD_BITS-1:0]);
        end
    end

    assign trig_en_q = cmd_q.trig_en;

    ftc_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_async  (ext_trig),
        .int_pulse  (int_trig),
        .ext_sel    (cmd_q.ext_sel),
        .trig_pulse (trig_raw)
    );

    ftc_handshake u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_en   (cmd_wdata[6]),
        .upd_wr   (upd_wr),
        .trig     (trig_raw),
        .ready    (ready),
        .overrun  (overrun),
        .acc_trig (acc_trig)
    );

    ftc_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (cmd_q.irq_lvl),
        .set   (acc_trig),
        .clr   (stat_rd | cmd_wr),
        .lines (irq_lines)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= acc_trig | (upd_wr & ~cmd_q.trig_en & cmd_q.hold);
        end
    end

    always_comb begin
        stat_word  = {ready, overrun, 2'b00, cur_chan,
                      cmd_q.hold, cmd_q.trig_en, cmd_q.ext_sel, cmd_q.auto_inc, din};
        dout       = cmd_q.dout;
        auto_inc   = cmd_q.auto_inc;
        hold_mode  = cmd_q.hold;
        upd_strobe = strobe_q;
    end

endmodule

// File: rtl/ftc_checker.sv
module ftc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wr,
    input logic [3:0] cmd_dout_in,
    input logic       upd_wr,
    input logic       stat_rd,
    input logic       ready,
    input logic       overrun,
    input logic [3:0] dout,
    input logic       hold,
    input logic       upd_strobe,
    input logic [4:0] irq_lines,
    input logic       trig_en_q,
    input logic       acc_trig
);

    a_r2_dout_load: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> dout == $past(cmd_dout_in));

    a_r4_arm_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_wr && trig_en_q && !acc_trig && !cmd_wr) |=> ready);

    a_r5_ready_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_en_q |-> !ready);

    a_r6_cmd_clears_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> !overrun);

    a_r8_strobe_after_trig: assert property (@(posedge clk) disable iff (!rst_n)
        acc_trig |=> upd_strobe);

    a_r9_sw_update_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_wr && !trig_en_q && hold) |=> upd_strobe);

    a_r11_read_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !acc_trig) |=> irq_lines == 5'b0);

    a_r12_irq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_lines));

endmodule

bind frame_trig_ctrl ftc_checker u_ftc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .cmd_dout_in (cmd_wdata[3:0]),
    .upd_wr      (upd_wr),
    .stat_rd     (stat_rd),
    .ready       (stat_word[15]),
    .overrun     (stat_word[14]),
    .dout        (dout),
    .hold        (hold_mode),
    .upd_strobe  (upd_strobe),
    .irq_lines   (irq_lines),
    .trig_en_q   (trig_en_q),
    .acc_trig    (acc_trig)
);

// File: tb/test_frame_trig_ctrl.sv
module test_frame_trig_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_wr, upd_wr, stat_rd, int_trig, ext_trig;
    logic [15:0] cmd_wdata;
    logic [3:0]  cur_chan, din;
    logic [15:0] stat_word;
    logic [3:0]  dout;
    logic        auto_inc, hold_mode, upd_strobe;
    logic [4:0]  irq_lines;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    frame_trig_ctrl i_frame_trig_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .upd_wr(upd_wr), .stat_rd(stat_rd), .cur_chan(cur_chan), .din(din),
        .int_trig(int_trig), .ext_trig(ext_trig), .stat_word(stat_word),
        .dout(dout), .auto_inc(auto_inc), .hold_mode(hold_mode),
        .upd_strobe(upd_strobe), .irq_lines(irq_lines)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_cmd(input logic [15:0] v);
        cmd_wr = 1'b1; cmd_wdata = v;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wr_upd();
        upd_wr = 1'b1;
        @(negedge clk);
        upd_wr = 1'b0;
    endtask

    task automatic pulse_int();
        int_trig = 1'b1;
        @(negedge clk);
        int_trig = 1'b0;
    endtask

    task automatic rd_stat();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 status", 32'(stat_word), 32'h0);
        check("R1 dout", 32'(dout), 32'h0);
        check("R1 irq", 32'(irq_lines), 32'h0);
        check("R1 strobe", 32'(upd_strobe), 32'h0);
    endtask

    task automatic t_cmd_fields();
        wr_cmd(16'hF8B5);
        check("R2 dout", 32'(dout), 32'h5);
        check("R2 auto_inc", 32'(auto_inc), 32'h1);
        check("R2 hold_mode", 32'(hold_mode), 32'h1);
        check("R3 echo bits", 32'(stat_word[7:4]), 32'hB);
    endtask

    task automatic t_status_layout();
        cur_chan = 4'h9; din = 4'hA;
        #1;
        check("R3 channel", 32'(stat_word[11:8]), 32'h9);
        check("R3 din", 32'(stat_word[3:0]), 32'hA);
        check("R3 zero bits", 32'(stat_word[13:12]), 32'h0);
        din = 4'h3;
        #1;
        check("R3 din live", 32'(stat_word[3:0]), 32'h3);
    endtask

    task automatic t_handshake();
        wr_cmd(16'h0040);
        check("R4 ready low", 32'(stat_word[15]), 32'h0);
        wr_upd();
        check("R4 armed", 32'(stat_word[15]), 32'h1);
        pulse_int();
        check("R4 cleared", 32'(stat_word[15]), 32'h0);
        check("R6 no overrun", 32'(stat_word[14]), 32'h0);
        check("R8 strobe high", 32'(upd_strobe), 32'h1);
        @(negedge clk);
        check("R8 strobe one cycle", 32'(upd_strobe), 32'h0);
    endtask

    task automatic t_overrun();
        wr_cmd(16'h0040);
        pulse_int();
        check("R6 overrun set", 32'(stat_word[14]), 32'h1);
        wr_upd();
        check("R6 overrun sticky", 32'(stat_word[14]), 32'h1);
        wr_cmd(16'h0040);
        check("R6 cmd clears", 32'(stat_word[14]), 32'h0);
        check("R4 still armed", 32'(stat_word[15]), 32'h1);
    endtask

    task automatic t_disabled();
        wr_cmd(16'h0100);
        wr_upd();
        check("R5 ready stays 0", 32'(stat_word[15]), 32'h0);
        pulse_int();
        check("R5 no strobe", 32'(upd_strobe), 32'h0);
        check("R5 no irq", 32'(irq_lines), 32'h0);
        check("R5 no overrun", 32'(stat_word[14]), 32'h0);
    endtask

    task automatic t_sw_update();
        wr_cmd(16'h0080);
        wr_upd();
        check("R9 sw strobe", 32'(upd_strobe), 32'h1);
        @(negedge clk);
        check("R9 strobe one cycle", 32'(upd_strobe), 32'h0);
        wr_cmd(16'h0000);
        wr_upd();
        check("R9 transparent no strobe", 32'(upd_strobe), 32'h0);
    endtask

    task automatic t_ext_trigger();
        wr_cmd(16'h0060);
        wr_upd();
        pulse_int();
        check("R7 int ignored", 32'(stat_word[15]), 32'h1);
        ext_trig = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7 not yet", 32'(stat_word[15]), 32'h1);
        @(negedge clk);
        check("R7 ext acts", 32'(stat_word[15]), 32'h0);
        check("R8 ext strobe", 32'(upd_strobe), 32'h1);
        wr_upd();
        repeat (5) @(negedge clk);
        check("R7 held level single", 32'(stat_word[15]), 32'h1);
        ext_trig = 1'b0;
        repeat (4) @(negedge clk);
        wr_cmd(16'h0040);
        pulse_int();
        check("R7 int used", 32'(stat_word[15]), 32'h0);
    endtask

    task automatic t_irq_decode();
        for (int code = 0; code < 8; code++) begin
            logic [4:0] exp;
            exp = (code >= 1 && code <= 5) ? 5'(1 << (code - 1)) : 5'h0;
            wr_cmd(16'h0040 | 16'(code << 8));
            wr_upd();
            pulse_int();
            check($sformatf("R10 code %0d", code), 32'(irq_lines), 32'(exp));
            rd_stat();
            check("R11 read clears", 32'(irq_lines), 32'h0);
        end
    endtask

    task automatic t_irq_set_wins();
        wr_cmd(16'h0540);
        wr_upd();
        int_trig = 1'b1; stat_rd = 1'b1;
        @(negedge clk);
        int_trig = 1'b0; stat_rd = 1'b0;
        check("R11 set wins", 32'(irq_lines), 32'h10);
        @(negedge clk);
        check("R11 sticky", 32'(irq_lines), 32'h10);
        wr_cmd(16'h0540);
        check("R11 cmd clears", 32'(irq_lines), 32'h0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_wr = 1'b0; cmd_wdata = '0; upd_wr = 1'b0;
        stat_rd = 1'b0; int_trig = 1'b0; ext_trig = 1'b0;
        cur_chan = 4'h0; din = 4'h0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_cmd_fields();
        t_status_layout();
        t_handshake();
        t_overrun();
        t_disabled();
        t_sw_update();
        t_ext_trigger();
        t_irq_decode();
        t_irq_set_wins();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule